// File: doc/BRIEF.md
# Partial Register Write Merge Unit

This block forms the 64-bit value that is written back into a general-purpose register when an instruction produces a result narrower than the register, or when a narrow source is widened by zero or sign extension. It takes the register's current contents, the freshly produced data and a small operation descriptor. It returns the complete word to be stored, so that the register file itself always performs a plain full-width write.

The merge rule depends on the width of the write. One-byte and two-byte writes preserve all bytes of the old value above the written field. A four-byte write clears the upper half instead. An eight-byte write replaces everything. Extension operations first widen the low part of the new data from a source size to a destination size. The widened result is then merged under the same rule at the destination size. A dedicated widening operation sign-extends the low half of the old register value into the whole register and ignores the new data.

The unit is combinational by default. Setting the `REGISTERED` parameter places one output register after the merge logic, which adds one cycle of latency.

Top module: `partial_write_merge`

## Requirements
- R1: Sizes are encoded on `src_size` and `dst_size` as 2'b00 = 1 byte, 2'b01 = 2 bytes, 2'b10 = 4 bytes, 2'b11 = 8 bytes. Operations are encoded on `op_kind` as 2'b00 = copy, 2'b01 = zero-extend, 2'b10 = sign-extend, 2'b11 = accumulator widen. A copy with `src_size` = 1 byte writes `new_val[7:0]` into bits 7:0 and keeps bits 63:8 of `old_val`.
- R2: A copy with `src_size` = 2 bytes writes `new_val[15:0]` into bits 15:0 and keeps bits 63:16 of `old_val`.
- R3: A copy with `src_size` = 4 bytes writes `new_val[31:0]` into bits 31:0 and forces bits 63:32 to zero.
- R4: A copy with `src_size` = 8 bytes, which is also how a 64-bit immediate load is performed, writes all of `new_val`.
- R5: Zero extension supports the source/destination pairs 1→2, 1→4, 2→4, 1→8 and 2→8 bytes. The bits between the source and destination widths become zero.
- R6: Sign extension supports the pairs 1→2, 1→4, 2→4, 1→8, 2→8 and 4→8 bytes. The bits between the source and destination widths copy the source's top bit.
- R7: An extended result narrower than 64 bits is merged at the destination size. A 2-byte destination keeps bits 63:16 of `old_val`, and a 4-byte destination clears bits 63:32.
- R8: Accumulator widen produces `old_val[31:0]` sign-extended to 64 bits. It ignores `new_val`, `src_size` and `dst_size`.
- R9: With `REGISTERED` = 0, `wr_val` follows the inputs with no clock delay. With `REGISTERED` = 1, `wr_val` presents the merged value one clock after the inputs are sampled, and it is zero after a clock edge with `rst_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the assertions |
| rst_n | input | 1 | Synchronous active-low reset |
| op_kind | input | 2 | Operation: copy, zero-extend, sign-extend, accumulator widen |
| src_size | input | 2 | Width of the copied data or of the extension source |
| dst_size | input | 2 | Destination width of an extension |
| old_val | input | 64 | Current contents of the destination register |
| new_val | input | 64 | Result or source data to be written |
| wr_val | output | 64 | Complete value to store in the register |

## Verification
The assertions assume that extension operations arrive only with a legal pair. For a legal pair, the destination is strictly wider than the source, and zero extension never uses a 4-byte source. The sign-pattern checks rely on that assumption. The directed stimulus uses only the pairs listed in R5 and R6, and it exercises the copy and widen operations with every size code and with deliberately inconsistent unused fields. Each case compares both the combinational instance and the registered instance against a model written independently in the bench.

// File: rtl/pwm_pkg.sv
// Shared encodings for the partial register write merge unit.
// Assumes a register width that is a multiple of eight bytes' worth of lanes.
package pwm_pkg;
    typedef enum logic [1:0] {
        SZ_1B = 2'b00,
        SZ_2B = 2'b01,
        SZ_4B = 2'b10,
        SZ_8B = 2'b11
    } opsize_e;

    typedef enum logic [1:0] {
        OP_COPY = 2'b00,
        OP_ZEXT = 2'b01,
        OP_SEXT = 2'b10,
        OP_ACCW = 2'b11
    } opkind_e;

    localparam int NUM_SIZES = 4;
endpackage

// File: rtl/pwm_extend.sv
// Widens the low 1/2/4/8-byte field of src to the full width, with zero or
// sign fill. Assumes size selects the source field; fill is taken from the
// field's top bit when sign_en is set.
module pwm_extend
    import pwm_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        size,
    input  logic              sign_en,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] ext_out
);
    localparam int LANE0_W = DATA_W / 8;
    localparam int LANE1_W = DATA_W / 4;

    logic [DATA_W-1:0] cand [NUM_SIZES];

    // One widened candidate per source size.
    for (genvar i = 0; i < NUM_SIZES; i++) begin : g_size
        localparam int W = DATA_W >> (NUM_SIZES - 1 - i);
        if (i == NUM_SIZES - 1) begin : g_full
            assign cand[i] = src;
        end else begin : g_part
            assign cand[i] = {{(DATA_W - W){sign_en & src[W-1]}}, src[W-1:0]};
        end
    end

    // Pick the candidate for the requested source size.
    always_comb begin
        ext_out = cand[size];
    end

    // R6: byte source with sign fill gives a uniform field above bit 6
    a_r6_sign_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (sign_en && size == SZ_1B) |->
            ((&ext_out[DATA_W-1:LANE0_W-1]) || !(|ext_out[DATA_W-1:LANE0_W-1])));
    // R5: zero fill above a two-byte source
    a_r5_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
        (!sign_en && size == SZ_2B) |-> (ext_out[DATA_W-1:LANE1_W] == '0));
    // R6: sign fill above a two-byte source follows bit 15 of the source
    a_r6_sign_word: assert property (@(posedge clk) disable iff (!rst_n)
        (sign_en && size == SZ_2B) |->
            (ext_out[DATA_W-1] == src[LANE1_W-1]));
endmodule

// File: rtl/pwm_merge.sv
// Combines write data with the old register contents for a given write size.
// Narrow (1- and 2-byte) writes keep the old upper bytes, a half-width write
// clears the upper half, a full write replaces everything.
module pwm_merge
    import pwm_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] merged
);
    localparam int LANE0_W = DATA_W / 8;
    localparam int LANE1_W = DATA_W / 4;
    localparam int LANE2_W = DATA_W / 2;

    logic [DATA_W-1:0] cand [NUM_SIZES];

    // One merged candidate per write size.
    for (genvar i = 0; i < NUM_SIZES; i++) begin : g_size
        localparam int W = DATA_W >> (NUM_SIZES - 1 - i);
        if (i == NUM_SIZES - 1) begin : g_full
            assign cand[i] = data;
        end else if (i == NUM_SIZES - 2) begin : g_clear
            assign cand[i] = {{(DATA_W - W){1'b0}}, data[W-1:0]};
        end else begin : g_keep
            assign cand[i] = {old_val[DATA_W-1:W], data[W-1:0]};
        end
    end

    // Pick the candidate for the requested write size.
    always_comb begin
        merged = cand[size];
    end

    // R1: byte write keeps the old upper bytes
    a_r1_keep_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_1B) |-> (merged[DATA_W-1:LANE0_W] == old_val[DATA_W-1:LANE0_W]
                             && merged[LANE0_W-1:0] == data[LANE0_W-1:0]));
    // R2: two-byte write keeps the old upper bytes
    a_r2_keep_word: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_2B) |-> (merged[DATA_W-1:LANE1_W] == old_val[DATA_W-1:LANE1_W]));
    // R3: four-byte write clears the upper half
    a_r3_clear_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_4B) |-> (merged[DATA_W-1:LANE2_W] == '0
                             && merged[LANE2_W-1:0] == data[LANE2_W-1:0]));
    // R4: full write takes the data unchanged
    a_r4_full_write: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_8B) |-> (merged == data));
endmodule

// File: rtl/partial_write_merge.sv
// Top of the partial register write merge unit. Decodes the operation into an
// extension step and a merge step and optionally registers the result.
// Assumes extension requests carry a legal source/destination pair.
module partial_write_merge
    import pwm_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter bit REGISTERED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_kind,
    input  logic [1:0]        src_size,
    input  logic [1:0]        dst_size,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] new_val,
    output logic [DATA_W-1:0] wr_val
);
    localparam int HALF_W = DATA_W / 2;

    opkind_e           kind;
    logic [1:0]        ext_size;
    logic              ext_sign;
    logic [DATA_W-1:0] ext_src;
    logic [DATA_W-1:0] ext_val;
    logic [1:0]        mrg_size;
    logic [DATA_W-1:0] mrg_data;
    logic [DATA_W-1:0] nxt_val;

    // Decode the operation into extension and merge controls.
    always_comb begin
        kind     = opkind_e'(op_kind);
        ext_src  = new_val;
        ext_size = src_size;
        ext_sign = 1'b0;
        mrg_size = dst_size;
        mrg_data = ext_val;
        unique case (kind)
            OP_COPY: begin
                mrg_size = src_size;
                mrg_data = new_val;
            end
            OP_ZEXT: ext_sign = 1'b0;
            OP_SEXT: ext_sign = 1'b1;
            OP_ACCW: begin
                ext_src  = old_val;
                ext_size = SZ_4B;
                ext_sign = 1'b1;
                mrg_size = SZ_8B;
            end
        endcase
    end

    pwm_extend #(.DATA_W(DATA_W)) u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .size    (ext_size),
        .sign_en (ext_sign),
        .src     (ext_src),
        .ext_out (ext_val)
    );

    pwm_merge #(.DATA_W(DATA_W)) u_mrg (
        .clk     (clk),
        .rst_n   (rst_n),
        .size    (mrg_size),
        .old_val (old_val),
        .data    (mrg_data),
        .merged  (nxt_val)
    );

    if (REGISTERED) begin : g_reg
        logic [DATA_W-1:0] out_q;

        // Hold the merged value for one cycle; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= nxt_val;
        end
        assign wr_val = out_q;

        // R9: registered output presents the previous cycle's merge
        a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (wr_val == $past(nxt_val)));
    end else begin : g_comb
        assign wr_val = nxt_val;
    end

    // R8: accumulator widen keeps the low half and replicates bit 31 upward
    a_r8_acc_widen: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == OP_ACCW) |-> (nxt_val[HALF_W-1:0] == old_val[HALF_W-1:0]
            && ((&nxt_val[DATA_W-1:HALF_W-1]) || !(|nxt_val[DATA_W-1:HALF_W-1]))));
    // R7: extension to a two-byte destination keeps the old upper bytes
    a_r7_ext_word_dst: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_kind == OP_ZEXT || op_kind == OP_SEXT) && dst_size == SZ_2B) |->
            (nxt_val[DATA_W-1:DATA_W/4] == old_val[DATA_W-1:DATA_W/4]));
    // R5: zero extension never sets a bit above the destination width
    a_r5_zext_dword: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == OP_ZEXT && dst_size == SZ_4B) |-> (nxt_val[DATA_W-1:HALF_W] == '0));
endmodule

// File: tb/sim_partial_write_merge.sv
module sim_partial_write_merge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [1:0]  src_size = 2'b00;
    logic [1:0]  dst_size = 2'b00;
    logic [63:0] old_val = '0;
    logic [63:0] new_val = '0;
    logic [63:0] wr_c;
    logic [63:0] wr_r;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    partial_write_merge #(.DATA_W(64), .REGISTERED(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .src_size(src_size),
        .dst_size(dst_size), .old_val(old_val), .new_val(new_val), .wr_val(wr_c));

    partial_write_merge #(.DATA_W(64), .REGISTERED(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .src_size(src_size),
        .dst_size(dst_size), .old_val(old_val), .new_val(new_val), .wr_val(wr_r));

    function automatic logic [63:0] model(input logic [1:0] k, input logic [1:0] ss,
                                          input logic [1:0] ds, input logic [63:0] o,
                                          input logic [63:0] n);
        logic [63:0] x;
        logic [1:0]  ws;
        x  = n;
        ws = ds;
        case (k)
            2'b00: ws = ss;
            2'b01: case (ss)
                2'b00:   x = {56'd0, n[7:0]};
                2'b01:   x = {48'd0, n[15:0]};
                default: x = {32'd0, n[31:0]};
            endcase
            2'b10: case (ss)
                2'b00:   x = 64'($signed(n[7:0]));
                2'b01:   x = 64'($signed(n[15:0]));
                default: x = 64'($signed(n[31:0]));
            endcase
            default: begin
                x  = 64'($signed(o[31:0]));
                ws = 2'b11;
            end
        endcase
        case (ws)
            2'b00:   return {o[63:8], x[7:0]};
            2'b01:   return {o[63:16], x[15:0]};
            2'b10:   return {32'd0, x[31:0]};
            default: return x;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one operation; check the combinational and the registered copies.
    task automatic run_op(input string req, input logic [1:0] k, input logic [1:0] ss,
                          input logic [1:0] ds, input logic [63:0] o, input logic [63:0] n);
        logic [63:0] exp;
        @(negedge clk);
        op_kind = k; src_size = ss; dst_size = ds; old_val = o; new_val = n;
        exp = model(k, ss, ds, o, n);
        #1 check(req, wr_c, exp);
        @(posedge clk);
        #1 check({req, "/R9"}, wr_r, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        old_val = 64'hFFFF_FFFF_FFFF_FFFF; new_val = 64'h1234_5678_9ABC_DEF0;
        repeat (2) @(posedge clk);
        #1 check("R9 reset", wr_r, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_copy;
        run_op("R1", 2'b00, 2'b00, 2'b11, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FF5A);
        check("R1 explicit", wr_c, 64'h0123_4567_89AB_CD5A);
        run_op("R2", 2'b00, 2'b01, 2'b00, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_BEEF);
        check("R2 explicit", wr_c, 64'h0123_4567_89AB_BEEF);
        run_op("R3", 2'b00, 2'b10, 2'b00, 64'hFFFF_FFFF_0000_0000, 64'hAAAA_AAAA_8765_4321);
        check("R3 explicit", wr_c, 64'h0000_0000_8765_4321);
        run_op("R4", 2'b00, 2'b11, 2'b01, 64'h1111_1111_1111_1111, 64'hFEDC_BA98_7654_3210);
        check("R4 explicit", wr_c, 64'hFEDC_BA98_7654_3210);
    endtask

    task automatic t_zext;
        run_op("R5 b->q", 2'b01, 2'b00, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_55F3);
        check("R5 explicit", wr_c, 64'h0000_0000_0000_00F3);
        run_op("R5 w->q", 2'b01, 2'b01, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_9001);
        run_op("R5 w->d", 2'b01, 2'b01, 2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_8001);
        run_op("R5 b->d R7", 2'b01, 2'b00, 2'b10, 64'hDEAD_BEEF_DEAD_BEEF, 64'h0000_0000_0000_0080);
        run_op("R5 b->w R7", 2'b01, 2'b00, 2'b01, 64'hDEAD_BEEF_DEAD_BEEF, 64'h0000_0000_0000_00C4);
        check("R7 explicit zext", wr_c, 64'hDEAD_BEEF_DEAD_00C4);
    endtask

    task automatic t_sext;
        run_op("R6 b->w R7", 2'b10, 2'b00, 2'b01, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0080);
        check("R7 explicit sext", wr_c, 64'h0123_4567_89AB_FF80);
        run_op("R6 b->d", 2'b10, 2'b00, 2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_007F);
        run_op("R6 b->q", 2'b10, 2'b00, 2'b11, 64'h0, 64'h0000_0000_0000_00FE);
        check("R6 explicit", wr_c, 64'hFFFF_FFFF_FFFF_FFFE);
        run_op("R6 w->d", 2'b10, 2'b01, 2'b10, 64'hAAAA_AAAA_AAAA_AAAA, 64'h0000_0000_0000_8000);
        run_op("R6 w->q", 2'b10, 2'b01, 2'b11, 64'h0, 64'hFFFF_FFFF_FFFF_7FFF);
        run_op("R6 d->q neg", 2'b10, 2'b10, 2'b11, 64'h0, 64'h0000_0000_8000_0001);
        run_op("R6 d->q pos", 2'b10, 2'b10, 2'b11, 64'h0, 64'hFFFF_FFFF_7FFF_FFFF);
    endtask

    task automatic t_widen;
        run_op("R8 neg", 2'b11, 2'b00, 2'b00, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R8 explicit", wr_c, 64'hFFFF_FFFF_9ABC_DEF0);
        run_op("R8 pos", 2'b11, 2'b01, 2'b10, 64'hFFFF_FFFF_7000_0001, 64'h0);
        check("R8 explicit pos", wr_c, 64'h0000_0000_7000_0001);
    endtask

    initial begin
        t_reset();
        t_copy();
        t_zext();
        t_sext();
        t_widen();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule